// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the status byte of a small 8-bit processor core: carry, zero, interrupt mask and decimal mode at the low end, three spare bits that software reaches only through a whole-byte restore, and a break position that exists only in the copy pushed to the stack. Each flag is updated from its own sources: ALU carry and zero-result strobes, dedicated set and clear commands, interrupt entry, a parallel restore after a pull from the stack, and reset. Each flag applies a fixed priority among these sources.

When an interrupt or a software break is entered, the block presents a push byte for the stack write. This byte is the live register as it stood before the entry, with the break position marked 1 for a software break and 0 for any other source. The interrupt mask is raised on the clock edge that ends the acceptance cycle, so the pushed copy still shows the mask as it was.

By default the decimal mode flag is left uninitialised by reset, so software must write it before arithmetic. A parameter can give it a reset value instead.

Top module: `psr_status_reg`

## Requirements
- R1: On reset, carry, zero and bits 7..5 become 0 and the interrupt mask (bit 2) becomes 1. With the default parameters, reset leaves the decimal flag (bit 3) at its previous value.
- R2: When `alu_c_we` is 1, carry (bit 0) takes `alu_c_val` at the next edge.
- R3: `set_c`/`clr_c`, `set_i`/`clr_i` and `set_d`/`clr_d` drive bits 0, 2 and 3 to 1 or 0 at the next edge. A command wins over an ALU carry update in the same cycle.
- R4: If the set and the clear command for one flag are both 1, that flag keeps its previous value, whatever ALU update arrives with them.
- R5: When `res_z_we` is 1, zero (bit 1) becomes `res_z_val`. No command writes it.
- R6: While decimal mode is 1, a zero update marked arithmetic (`res_z_arith`=1) leaves zero unchanged. A data-transfer update (`res_z_arith`=0) still applies.
- R7: `int_accept` sets the interrupt mask at the next edge. This beats `clr_i` and the restore value in the same cycle.
- R8: During `int_accept`, `push_byte` bits 0..3 and 5..7 equal the live register before that edge, and bit 4 equals `int_brk` (1 = software break, 0 = other source).
- R9: Bit 4 of `status_q` is always 0. The restore ignores bit 4 of `load_val`.
- R10: `load_we` copies `load_val` bits 0..3 and 5..7 into the register in one edge. This beats ALU updates and commands, except the interrupt mask set of R7.
- R11: Bits 7..5 change only through the restore (and reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_c_we | input | 1 | Carry update strobe from the ALU or shifter |
| alu_c_val | input | 1 | Carry or borrow, or the shifted-out bit |
| res_z_we | input | 1 | Zero update strobe |
| res_z_val | input | 1 | 1 when the result is zero |
| res_z_arith | input | 1 | 1 for arithmetic results, 0 for data transfers |
| set_c | input | 1 | Set carry command |
| clr_c | input | 1 | Clear carry command |
| set_i | input | 1 | Set interrupt mask command |
| clr_i | input | 1 | Clear interrupt mask command |
| set_d | input | 1 | Set decimal mode command |
| clr_d | input | 1 | Clear decimal mode command |
| int_accept | input | 1 | Interrupt or break entry pulse |
| int_brk | input | 1 | 1 when the entry comes from a software break |
| load_we | input | 1 | Restore strobe (pull from stack) |
| load_val | input | DATA_W | Byte to restore |
| status_q | output | DATA_W | Live register |
| push_byte | output | DATA_W | Byte for the stack push |

## Verification
Several sources can target the same flag in one cycle, and these collisions are where the priorities matter. Interrupt entry can arrive with a clear-mask command and with a restore whose mask bit is 0; the mask must still read 1 afterwards, and the push byte sampled before the edge must show the old mask. A carry command can meet an ALU carry strobe of the opposite value, and a set-clear pair can meet an ALU strobe. Table rows drive each collision, the push byte is checked before the edge and the live register after it, and each result is compared with the value the priority order predicts.

// File: rtl/psr_pkg.sv
package psr_pkg;
   // Fixed flag positions inside the status byte
   localparam int unsigned POS_C    = 0;
   localparam int unsigned POS_Z    = 1;
   localparam int unsigned POS_I    = 2;
   localparam int unsigned POS_D    = 3;
   localparam int unsigned POS_B    = 4;
   // First bit above the defined flags
   localparam int unsigned FLAG_TOP = 5;
endpackage

// File: rtl/psr_flag_cell.sv
// One status flag with a fixed source priority:
// force > load > set/clear command > result update.
module psr_flag_cell #(
   parameter bit HAS_RST = 1'b1,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_en,
   input  logic force_val,
   input  logic load_en,
   input  logic load_val,
   input  logic set_cmd,
   input  logic clr_cmd,
   input  logic upd_en,
   input  logic upd_val,
   output logic flag_q
);
   logic q;
   logic nxt;

   always_comb begin
      nxt = q;
      if (force_en)              nxt = force_val;
      else if (load_en)          nxt = load_val;
      else if (set_cmd & clr_cmd) nxt = q;       // illegal pair: hold
      else if (set_cmd)          nxt = 1'b1;
      else if (clr_cmd)          nxt = 1'b0;
      else if (upd_en)           nxt = upd_val;
   end

   generate
      if (HAS_RST) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= nxt;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) q <= nxt;
      end
   endgenerate

   assign flag_q = q;
endmodule

// File: rtl/psr_spare_bits.sv
// Bits above the defined flags: written only by the restore path.
module psr_spare_bits #(
   parameter int unsigned SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [SW-1:0] load_val,
   output logic [SW-1:0] bits_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bits_q <= '0;
      else if (load_en) bits_q <= load_val;
   end
endmodule

// File: rtl/psr_push_fmt.sv
// Builds the stacked copy: live byte with the break position substituted.
module psr_push_fmt #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] live,
   input  logic              brk,
   output logic [DATA_W-1:0] push
);
   import psr_pkg::*;
   always_comb begin
      push        = live;
      push[POS_B] = brk;
   end
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg #(
   parameter int unsigned DATA_W       = 8,
   parameter bit          DEC_RESET_EN = 1'b0,
   parameter bit          DEC_RST_VAL  = 1'b0,
   parameter bit          I_RST_VAL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_c_we,
   input  logic              alu_c_val,
   input  logic              res_z_we,
   input  logic              res_z_val,
   input  logic              res_z_arith,
   input  logic              set_c,
   input  logic              clr_c,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic              set_d,
   input  logic              clr_d,
   input  logic              int_accept,
   input  logic              int_brk,
   input  logic              load_we,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] push_byte
);
   import psr_pkg::*;

   localparam int unsigned SPARE_W = DATA_W - FLAG_TOP;
   localparam int unsigned SPARE_S = (SPARE_W > 0) ? SPARE_W : 1;

   generate
      if (DATA_W < FLAG_TOP || DATA_W > 16) begin : g_bad_w
         $error("psr_status_reg: DATA_W must lie in 5..16");
      end
      if (!DEC_RESET_EN && DEC_RST_VAL) begin : g_bad_dec
         $error("psr_status_reg: DEC_RST_VAL needs DEC_RESET_EN");
      end
   endgenerate

   logic c_q, z_q, i_q, d_q;
   logic [SPARE_S-1:0] spare_q;
   logic z_upd;

   // Arithmetic zero is not meaningful in decimal mode: hold it there
   assign z_upd = res_z_we & ~(res_z_arith & d_q);

   psr_flag_cell #(.HAS_RST(1'b1), .RST_VAL(1'b0)) u_c (
      .clk(clk), .rst_n(rst_n),
      .force_en(1'b0), .force_val(1'b0),
      .load_en(load_we), .load_val(load_val[POS_C]),
      .set_cmd(set_c), .clr_cmd(clr_c),
      .upd_en(alu_c_we), .upd_val(alu_c_val),
      .flag_q(c_q)
   );

   psr_flag_cell #(.HAS_RST(1'b1), .RST_VAL(1'b0)) u_z (
      .clk(clk), .rst_n(rst_n),
      .force_en(1'b0), .force_val(1'b0),
      .load_en(load_we), .load_val(load_val[POS_Z]),
      .set_cmd(1'b0), .clr_cmd(1'b0),
      .upd_en(z_upd), .upd_val(res_z_val),
      .flag_q(z_q)
   );

   psr_flag_cell #(.HAS_RST(1'b1), .RST_VAL(I_RST_VAL)) u_i (
      .clk(clk), .rst_n(rst_n),
      .force_en(int_accept), .force_val(1'b1),
      .load_en(load_we), .load_val(load_val[POS_I]),
      .set_cmd(set_i), .clr_cmd(clr_i),
      .upd_en(1'b0), .upd_val(1'b0),
      .flag_q(i_q)
   );

   psr_flag_cell #(.HAS_RST(DEC_RESET_EN), .RST_VAL(DEC_RST_VAL)) u_d (
      .clk(clk), .rst_n(rst_n),
      .force_en(1'b0), .force_val(1'b0),
      .load_en(load_we), .load_val(load_val[POS_D]),
      .set_cmd(set_d), .clr_cmd(clr_d),
      .upd_en(1'b0), .upd_val(1'b0),
      .flag_q(d_q)
   );

   generate
      if (SPARE_W > 0) begin : g_spare
         psr_spare_bits #(.SW(SPARE_W)) u_sp (
            .clk(clk), .rst_n(rst_n),
            .load_en(load_we),
            .load_val(load_val[DATA_W-1:FLAG_TOP]),
            .bits_q(spare_q)
         );
      end else begin : g_nospare
         assign spare_q = '0;
      end
   endgenerate

   logic unused_ld_b;
   assign unused_ld_b = load_val[POS_B];

   always_comb begin
      status_q        = '0;
      status_q[POS_C] = c_q;
      status_q[POS_Z] = z_q;
      status_q[POS_I] = i_q;
      status_q[POS_D] = d_q;
      for (int k = FLAG_TOP; k < DATA_W; k++) status_q[k] = spare_q[k-FLAG_TOP];
   end

   psr_push_fmt #(.DATA_W(DATA_W)) u_push (
      .live(status_q), .brk(int_brk), .push(push_byte)
   );
endmodule

// File: rtl/psr_status_chk.sv
module psr_status_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alu_c_we,
   input logic              alu_c_val,
   input logic              res_z_we,
   input logic              res_z_val,
   input logic              res_z_arith,
   input logic              set_c,
   input logic              clr_c,
   input logic              set_i,
   input logic              clr_i,
   input logic              set_d,
   input logic              clr_d,
   input logic              int_accept,
   input logic              int_brk,
   input logic              load_we,
   input logic [DATA_W-1:0] load_val,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] push_byte
);
   import psr_pkg::*;

   a_r1_reset_mask: assert property (@(posedge clk) $rose(rst_n) |-> status_q[POS_I] && !status_q[POS_C]);

   a_r2_alu_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_c_we && !set_c && !clr_c && !load_we) |=> status_q[POS_C] == $past(alu_c_val));

   a_r3_set_c_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_c && !clr_c && !load_we) |=> status_q[POS_C]);

   a_r4_d_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_d && clr_d && !load_we) |=> $stable(status_q[POS_D]));

   a_r6_dec_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (res_z_we && res_z_arith && status_q[POS_D] && !load_we) |=> $stable(status_q[POS_Z]));

   a_r7_int_mask: assert property (@(posedge clk) disable iff (!rst_n)
      int_accept |=> status_q[POS_I]);

   a_r8_push_copy: assert property (@(posedge clk) disable iff (!rst_n)
      int_accept |-> (push_byte[POS_B] == int_brk) && (push_byte[3:0] == status_q[3:0]));

   a_r9_no_live_brk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_q[POS_B]);

   a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (load_we && !int_accept) |=> status_q[3:0] == $past(load_val[3:0]));

   a_r11_spare_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load_we |=> $stable(status_q[DATA_W-1:FLAG_TOP]));
endmodule

bind psr_status_reg psr_status_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .alu_c_we(alu_c_we), .alu_c_val(alu_c_val),
   .res_z_we(res_z_we), .res_z_val(res_z_val), .res_z_arith(res_z_arith),
   .set_c(set_c), .clr_c(clr_c), .set_i(set_i), .clr_i(clr_i),
   .set_d(set_d), .clr_d(clr_d),
   .int_accept(int_accept), .int_brk(int_brk),
   .load_we(load_we), .load_val(load_val),
   .status_q(status_q), .push_byte(push_byte)
);

// File: tb/sim_psr_status_reg.sv
`timescale 1ns/1ps
module sim_psr_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alu_c_we = 0, alu_c_val = 0;
   logic       res_z_we = 0, res_z_val = 0, res_z_arith = 0;
   logic       set_c = 0, clr_c = 0, set_i = 0, clr_i = 0, set_d = 0, clr_d = 0;
   logic       int_accept = 0, int_brk = 0, load_we = 0;
   logic [7:0] load_val = 8'h00;
   logic [7:0] status_q, push_byte;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   psr_status_reg u0 (
      .clk(clk), .rst_n(rst_n),
      .alu_c_we(alu_c_we), .alu_c_val(alu_c_val),
      .res_z_we(res_z_we), .res_z_val(res_z_val), .res_z_arith(res_z_arith),
      .set_c(set_c), .clr_c(clr_c), .set_i(set_i), .clr_i(clr_i),
      .set_d(set_d), .clr_d(clr_d),
      .int_accept(int_accept), .int_brk(int_brk),
      .load_we(load_we), .load_val(load_val),
      .status_q(status_q), .push_byte(push_byte)
   );

   typedef struct packed {
      logic [3:0] rq;
      logic       ld;
      logic [7:0] ldv;
      logic       sc, cc, si, ci, sd, cd;
      logic       cwe, cv, zwe, zv, za, ia, brk;
      logic [7:0] ep, es;
   } vec_t;

   // rq, ld, ldv, sc,cc,si,ci,sd,cd, cwe,cv, zwe,zv,za, ia,brk, push, status
   localparam vec_t TBL [17] = '{
      '{4'd3,  0, 8'h00, 0,0,0,0,0,1, 0,0, 0,0,0, 0,0, 8'h00, 8'h04}, // R3 clear D
      '{4'd2,  0, 8'h00, 0,0,0,0,0,0, 1,1, 0,0,0, 0,0, 8'h00, 8'h05}, // R2 carry in
      '{4'd5,  0, 8'h00, 0,0,0,0,0,0, 0,0, 1,1,1, 0,0, 8'h00, 8'h07}, // R5 zero set
      '{4'd3,  0, 8'h00, 0,0,0,1,0,0, 0,0, 0,0,0, 0,0, 8'h00, 8'h03}, // R3 clear I
      '{4'd3,  0, 8'h00, 1,0,0,0,0,0, 1,0, 1,0,0, 0,0, 8'h00, 8'h01}, // R3 set_c beats ALU 0
      '{4'd3,  0, 8'h00, 0,0,0,0,1,0, 0,0, 0,0,0, 0,0, 8'h00, 8'h09}, // R3 set D
      '{4'd6,  0, 8'h00, 0,1,0,0,0,0, 0,0, 1,1,1, 0,0, 8'h00, 8'h08}, // R6 arith Z held
      '{4'd6,  0, 8'h00, 0,0,0,0,0,0, 0,0, 1,1,0, 0,0, 8'h00, 8'h0A}, // R6 transfer Z applies
      '{4'd4,  0, 8'h00, 1,1,0,0,0,0, 1,1, 0,0,0, 0,0, 8'h00, 8'h0A}, // R4 C pair holds
      '{4'd7,  0, 8'h00, 0,0,0,1,0,0, 0,0, 0,0,0, 1,1, 8'h1A, 8'h0E}, // R7 R8 break entry
      '{4'd3,  0, 8'h00, 0,0,0,1,0,0, 0,0, 0,0,0, 0,0, 8'h00, 8'h0A}, // R3 clear I
      '{4'd8,  0, 8'h00, 0,0,0,0,0,0, 0,0, 0,0,0, 1,0, 8'h0A, 8'h0E}, // R8 hw entry
      '{4'd10, 1, 8'hF5, 0,0,0,0,1,0, 1,0, 0,0,0, 0,0, 8'h00, 8'hE5}, // R10 R9 restore
      '{4'd7,  1, 8'h00, 0,0,0,0,0,0, 0,0, 0,0,0, 1,0, 8'hE5, 8'h04}, // R7 entry beats load I
      '{4'd4,  0, 8'h00, 0,0,1,1,1,1, 0,0, 0,0,0, 0,0, 8'h00, 8'h04}, // R4 I and D pairs
      '{4'd3,  0, 8'h00, 0,0,0,0,1,0, 1,1, 0,0,0, 0,0, 8'h00, 8'h0D}, // R3 set D + R2
      '{4'd3,  0, 8'h00, 0,0,0,0,0,1, 0,0, 0,0,0, 0,0, 8'h00, 8'h05}  // R3 clear D
   };

   task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
      end
   endtask

   task automatic idle();
      {alu_c_we, alu_c_val, res_z_we, res_z_val, res_z_arith} = '0;
      {set_c, clr_c, set_i, clr_i, set_d, clr_d} = '0;
      {int_accept, int_brk, load_we} = '0;
      load_val = 8'h00;
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      load_we = v.ld; load_val = v.ldv;
      set_c = v.sc; clr_c = v.cc; set_i = v.si; clr_i = v.ci; set_d = v.sd; clr_d = v.cd;
      alu_c_we = v.cwe; alu_c_val = v.cv;
      res_z_we = v.zwe; res_z_val = v.zv; res_z_arith = v.za;
      int_accept = v.ia; int_brk = v.brk;
      if ((v.sc & v.cc) | (v.si & v.ci) | (v.sd & v.cd))
         $display("NOTE illegal set/clear pair driven (R4), expecting hold");
      #1;
      if (v.ia) check($sformatf("R%0d push", v.rq), push_byte, v.ep);
      @(posedge clk);
      #1;
      check($sformatf("R%0d status", v.rq), status_q, v.es);
      @(negedge clk);
      idle();
   endtask

   task automatic one_load(input logic [7:0] val);
      vec_t v;
      v = '0;
      v.ld = 1'b1; v.ldv = val;
      @(negedge clk);
      load_we = 1'b1; load_val = val;
      @(posedge clk);
      #1;
      @(negedge clk);
      idle();
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values, decimal flag excluded (not initialised)
      check("R1 reset", status_q & 8'hF7, 8'h04);
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < 17; n++) apply(TBL[n]);

      // R9: restore bit 4 is ignored
      one_load(8'h10);
      check("R9 restore bit4", status_q, 8'h00);

      // R11: spare bits survive commands, ALU and entry
      one_load(8'hE0);
      check("R11 spare load", status_q, 8'hE0);
      apply('{4'd11, 0, 8'h00, 1,0,0,0,0,0, 1,0, 1,1,0, 0,0, 8'h00, 8'hE3});
      apply('{4'd11, 0, 8'h00, 0,0,0,0,0,0, 0,0, 0,0,0, 1,1, 8'hF3, 8'hE7});

      // R1: reset mid-run clears C, Z, spare, sets I, keeps D
      one_load(8'hEB);
      check("R1 pre-reset", status_q, 8'hEB);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1 mid-run reset", status_q, 8'h0C);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", status_q, 8'h0C);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule